// File: doc/BRIEF.md
# Sticky Fault Interrupt Aggregator

This block gathers fault reports from around a power-management device into three byte-wide sticky status registers and drives an active-low interrupt pin. The registers form two levels. A primary source byte reports pin faults and an emergency power-down event. A secondary byte reports internal faults: a regulator fault, thermal shutdown and a runtime register CRC error. An 8-bit vendor fault byte has an enable byte beside it. The top bit of the primary byte is a live OR of the secondary byte. The top bit of the secondary byte is a live OR of the vendor byte. A host can therefore start from the primary byte and walk down to the exact cause.

Level-type faults set their bit while the condition is present. A host write of 1 clears such a bit only once the condition has gone away. Event-type faults set their bit on a one-cycle pulse, and a write of 1 clears them at any time. The interrupt pin goes low whenever any primary bit is set, or whenever the host sets the force control bit. A read-only status byte shows the current pin state, so software can see whether this block is the one asserting the interrupt.

Register map (3-bit address): 0 primary source, 1 secondary internal faults, 2 vendor faults, 3 vendor enables, 4 control, 5 status, 6 and 7 unused.

Top module: `fault_irq_agg`

## Requirements
- R1: Synchronous reset (`rst` high) clears every status, enable and control register to 0x00 and sets `irq_n` to 1.
- R2: Status bits clear by writing 1 to them. Writing 0 changes nothing. The event bits (primary bit 6 set by `evt_pls[0]`, secondary bit 5 set by `evt_pls[1]`) clear on a write of 1 whatever the state of their source.
- R3: The level bits are primary bit 2 (`lvl_flt[0]`), primary bit 0 (`lvl_flt[1]`), secondary bit 3 (`lvl_flt[2]`) and secondary bit 2 (`lvl_flt[3]`). Each one sets while its input is high and stays set after the input falls. A write of 1 clears it only if its input is low in that cycle.
- R4: A fault pulse or level in the same cycle as a clearing write wins, so the bit stays set.
- R5: Primary bit 7 reads as the OR of all secondary bits. A write to primary bit 7 has no effect.
- R6: Secondary bit 7 reads as the OR of all vendor fault bits. A write to secondary bit 7 has no effect.
- R7: Vendor fault bit i is captured from `vnd_pls[i]` only while bit i of the enable register (address 3, read/write, reset 0x00) is 1.
- R8: With force clear, `irq_n` is 0 in the cycle after the primary byte is nonzero and 1 in the cycle after it is zero.
- R9: Control bit 0 (address 4) set to 1 holds `irq_n` at 0 from the next cycle onward, whatever the status bits hold.
- R10: The status byte (address 5) reads the registered `irq_n` value in bit 5 and 0 in every other bit. Writes to it are ignored.
- R11: `rdata` is registered. It shows the register addressed in the previous cycle. Unused addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data (1 bits clear status bits) |
| wr_en | input | 1 | Write strobe |
| rdata | output | DATA_W | Registered read data |
| lvl_flt | input | 4 | Level fault conditions |
| evt_pls | input | 2 | Event pulses: emergency power-down, register CRC error |
| vnd_pls | input | DATA_W | Vendor fault pulses |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench tries to clear a level fault while its condition is still high. A design that ignored the condition would drop the bit and release the interrupt too early. It fires a pulse in the same cycle as a clearing write, and a design that gave the write priority would lose that fault. It writes 1 to both summary bits and pulses vendor faults with their enables off. Either mistake would show as a summary bit that reads wrong, or as a vendor bit set with no enable. It also releases the force bit and checks that the status byte follows the pin only one cycle later.

// File: rtl/fault_irq_agg_pkg.sv
package fault_irq_agg_pkg;
  // register addresses
  localparam int A_PRIM = 0;
  localparam int A_SEC  = 1;
  localparam int A_VND  = 2;
  localparam int A_VEN  = 3;
  localparam int A_CTL  = 4;
  localparam int A_STAT = 5;
  // summary bit and pin-state bit positions
  localparam int SUM_POS  = 7;
  localparam int PIN_POS  = 5;
  // level sources: register and bit for lvl_flt[i]
  localparam int N_LVL = 4;
  localparam int LVL_REG [N_LVL] = '{A_PRIM, A_PRIM, A_SEC, A_SEC};
  localparam int LVL_POS [N_LVL] = '{2, 0, 3, 2};
  // event sources: register and bit for evt_pls[i]
  localparam int N_EVT = 2;
  localparam int EVT_REG [N_EVT] = '{A_PRIM, A_SEC};
  localparam int EVT_POS [N_EVT] = '{6, 5};
endpackage

// File: rtl/fault_sticky_bit.sv
// One sticky status bit: a set input beats a clearing write in the same cycle.
module fault_sticky_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/fault_irq_drive.sv
// Registered active-low interrupt driver.
module fault_irq_drive (
  input  logic clk,
  input  logic rst,
  input  logic force_i,
  input  logic pend_i,
  output logic irq_n_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_n_o <= 1'b1;
    else     irq_n_o <= ~(force_i | pend_i);
  end
endmodule

// File: rtl/fault_irq_agg.sv
module fault_irq_agg
  import fault_irq_agg_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rdata,
  input  logic [N_LVL-1:0]  lvl_flt,
  input  logic [N_EVT-1:0]  evt_pls,
  input  logic [DATA_W-1:0] vnd_pls,
  output logic              irq_n
);
  localparam int N_REGS = 2 ** ADDR_W;

  // one-hot write decode
  logic [N_REGS-1:0] wsel;
  always_comb begin
    wsel = '0;
    if (wr_en) wsel[addr] = 1'b1;
  end

  // level-type bits
  logic [N_LVL-1:0] lvl_q;
  for (genvar i = 0; i < N_LVL; i++) begin : g_lvl
    fault_sticky_bit u_bit (
      .clk  (clk),
      .rst  (rst),
      .set_i(lvl_flt[i]),
      .clr_i(wsel[LVL_REG[i]] & wdata[LVL_POS[i]]),
      .q_o  (lvl_q[i])
    );
  end

  // event-type bits
  logic [N_EVT-1:0] evt_q;
  for (genvar i = 0; i < N_EVT; i++) begin : g_evt
    fault_sticky_bit u_bit (
      .clk  (clk),
      .rst  (rst),
      .set_i(evt_pls[i]),
      .clr_i(wsel[EVT_REG[i]] & wdata[EVT_POS[i]]),
      .q_o  (evt_q[i])
    );
  end

  // vendor enable and control registers
  logic [DATA_W-1:0] vnd_en;
  logic              force_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      vnd_en  <= '0;
      force_q <= 1'b0;
    end else begin
      if (wsel[A_VEN]) vnd_en  <= wdata;
      if (wsel[A_CTL]) force_q <= wdata[0];
    end
  end

  // vendor fault bits, gated by their enables
  logic [DATA_W-1:0] vnd_q;
  for (genvar i = 0; i < DATA_W; i++) begin : g_vnd
    fault_sticky_bit u_bit (
      .clk  (clk),
      .rst  (rst),
      .set_i(vnd_pls[i] & vnd_en[i]),
      .clr_i(wsel[A_VND] & wdata[i]),
      .q_o  (vnd_q[i])
    );
  end

  // assemble register views with live summary bits
  logic [DATA_W-1:0] prim_view, sec_view;
  always_comb begin
    prim_view = '0;
    sec_view  = '0;
    for (int i = 0; i < N_LVL; i++) begin
      if (LVL_REG[i] == A_PRIM) prim_view[LVL_POS[i]] = lvl_q[i];
      else                      sec_view[LVL_POS[i]]  = lvl_q[i];
    end
    for (int i = 0; i < N_EVT; i++) begin
      if (EVT_REG[i] == A_PRIM) prim_view[EVT_POS[i]] = evt_q[i];
      else                      sec_view[EVT_POS[i]]  = evt_q[i];
    end
    sec_view[SUM_POS]  = |vnd_q;
    prim_view[SUM_POS] = |sec_view;
  end

  fault_irq_drive u_irq (
    .clk    (clk),
    .rst    (rst),
    .force_i(force_q),
    .pend_i (|prim_view),
    .irq_n_o(irq_n)
  );

  // registered read mux
  logic [DATA_W-1:0] stat_view;
  always_comb begin
    stat_view          = '0;
    stat_view[PIN_POS] = irq_n;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (int'(addr))
        A_PRIM:  rdata <= prim_view;
        A_SEC:   rdata <= sec_view;
        A_VND:   rdata <= vnd_q;
        A_VEN:   rdata <= vnd_en;
        A_CTL:   rdata <= {{(DATA_W-1){1'b0}}, force_q};
        A_STAT:  rdata <= stat_view;
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/fault_irq_agg_chk.sv
module fault_irq_agg_chk
  import fault_irq_agg_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              wr_en,
  input logic [N_LVL-1:0]  lvl_flt,
  input logic [N_EVT-1:0]  evt_pls,
  input logic [DATA_W-1:0] vnd_pls,
  input logic              irq_n,
  input logic [DATA_W-1:0] prim_view,
  input logic [DATA_W-1:0] sec_view,
  input logic [DATA_W-1:0] vnd_q,
  input logic [DATA_W-1:0] vnd_en,
  input logic              force_q
);
  AST_RESET_CLEAN: assert property (@(posedge clk) rst |=> (irq_n && prim_view == '0 && vnd_q == '0 && vnd_en == '0)); // R1
  AST_IRQ_ON: assert property (@(posedge clk) disable iff (rst) (prim_view != '0) |=> !irq_n); // R8
  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (rst) (!force_q && prim_view == '0) |=> irq_n); // R8
  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (rst) force_q |=> !irq_n); // R9
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst) (wr_en && int'(addr) == A_PRIM && wdata[2] && lvl_flt[0]) |=> prim_view[2]); // R3
  AST_EVENT_CLEAR: assert property (@(posedge clk) disable iff (rst) (wr_en && int'(addr) == A_SEC && wdata[5] && !evt_pls[1]) |=> !sec_view[5]); // R2
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst) evt_pls[0] |=> prim_view[6]); // R4
  AST_VND_GATED: assert property (@(posedge clk) disable iff (rst) (vnd_q == '0 && (vnd_pls & vnd_en) == '0) |=> vnd_q == '0); // R7
endmodule

bind fault_irq_agg fault_irq_agg_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
  .lvl_flt(lvl_flt), .evt_pls(evt_pls), .vnd_pls(vnd_pls), .irq_n(irq_n),
  .prim_view(prim_view), .sec_view(sec_view), .vnd_q(vnd_q), .vnd_en(vnd_en),
  .force_q(force_q)
);

// File: tb/fault_irq_agg_tb.sv
module fault_irq_agg_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0;
  logic [7:0] rdata;
  logic [3:0] lvl_flt = '0;
  logic [1:0] evt_pls = '0;
  logic [7:0] vnd_pls = '0;
  logic       irq_n;

  int checks = 0;
  int errors = 0;
  bit live = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  fault_irq_agg u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rdata(rdata), .lvl_flt(lvl_flt), .evt_pls(evt_pls), .vnd_pls(vnd_pls),
    .irq_n(irq_n)
  );

  // behavioural reference model
  byte unsigned m_p, m_s, m_v, m_en, m_rd;
  bit m_frc, m_irqn;

  always @(posedge clk) begin
    byte unsigned sv, pv;
    bit nirq;
    if (rst) begin
      m_p = 0; m_s = 0; m_v = 0; m_en = 0; m_rd = 0; m_frc = 0; m_irqn = 1;
    end else begin
      sv = m_s | ((m_v != 0) ? 8'h80 : 8'h00);
      pv = m_p | ((sv != 0) ? 8'h80 : 8'h00);
      case (addr)
        3'd0: m_rd = pv;
        3'd1: m_rd = sv;
        3'd2: m_rd = m_v;
        3'd3: m_rd = m_en;
        3'd4: m_rd = {7'd0, m_frc};
        3'd5: m_rd = m_irqn ? 8'h20 : 8'h00;
        default: m_rd = 0;
      endcase
      nirq = !(m_frc || pv != 0);
      if (wr_en && addr == 3'd0) m_p = m_p & ~(wdata & 8'h45);
      if (wr_en && addr == 3'd1) m_s = m_s & ~(wdata & 8'h2C);
      if (wr_en && addr == 3'd2) m_v = m_v & ~wdata;
      if (lvl_flt[0]) m_p[2] = 1;
      if (lvl_flt[1]) m_p[0] = 1;
      if (lvl_flt[2]) m_s[3] = 1;
      if (lvl_flt[3]) m_s[2] = 1;
      if (evt_pls[0]) m_p[6] = 1;
      if (evt_pls[1]) m_s[5] = 1;
      m_v = m_v | (vnd_pls & m_en);
      if (wr_en && addr == 3'd3) m_en = wdata;
      if (wr_en && addr == 3'd4) m_frc = wdata[0];
      m_irqn = nirq;
    end
  end

  // compare against the model on every clock
  always @(negedge clk) begin
    if (live && !done) begin
      checks += 2;
      if (rdata !== m_rd) begin
        errors++;
        $display("FAIL R11 model rdata actual %02h expected %02h", rdata, m_rd);
      end
      if (irq_n !== m_irqn) begin
        errors++;
        $display("FAIL R8 model irq_n actual %0b expected %0b", irq_n, m_irqn);
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rdchk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a;
    @(negedge clk); chk(tag, rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        live = 1;
        // R1 reset state
        chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
        rdchk("R1 prim", 3'd0, 8'h00);
        rdchk("R1 sec", 3'd1, 8'h00);
        rdchk("R1 vnd", 3'd2, 8'h00);
        rdchk("R1 ven", 3'd3, 8'h00);
        rdchk("R10 stat idle", 3'd5, 8'h20);
        rdchk("R11 unused", 3'd6, 8'h00);
        // R3 level fault held while present
        @(negedge clk); lvl_flt = 4'b0001;
        idle(2);
        rdchk("R3 set", 3'd0, 8'h04);
        chk("R8 irq low", {7'd0, irq_n}, 8'h00);
        wr(3'd0, 8'h04);
        rdchk("R3 clear blocked", 3'd0, 8'h04);
        @(negedge clk); lvl_flt = 4'b0000;
        rdchk("R3 sticky", 3'd0, 8'h04);
        wr(3'd0, 8'h00);
        rdchk("R2 write zero", 3'd0, 8'h04);
        wr(3'd0, 8'h04);
        rdchk("R3 clear ok", 3'd0, 8'h00);
        chk("R8 irq high", {7'd0, irq_n}, 8'h01);
        // R3 secondary level bits and pin fault
        @(negedge clk); lvl_flt = 4'b1110;
        @(negedge clk); lvl_flt = 4'b0000;
        rdchk("R3 sec lvl", 3'd1, 8'h0C);
        rdchk("R5 prim sum", 3'd0, 8'h81);
        wr(3'd1, 8'h0C);
        wr(3'd0, 8'h01);
        rdchk("R3 sec cleared", 3'd1, 8'h00);
        rdchk("R5 prim clear", 3'd0, 8'h00);
        // R2 event bit clears on write
        @(negedge clk); evt_pls = 2'b10;
        @(negedge clk); evt_pls = 2'b00;
        rdchk("R2 crc set", 3'd1, 8'h20);
        rdchk("R5 summary", 3'd0, 8'h80);
        wr(3'd0, 8'h80);
        rdchk("R5 write ignored", 3'd0, 8'h80);
        wr(3'd1, 8'h20);
        rdchk("R2 crc cleared", 3'd1, 8'h00);
        rdchk("R5 summary gone", 3'd0, 8'h00);
        // R4 event and clearing write in the same cycle
        @(negedge clk); addr = 3'd0; wdata = 8'h40; wr_en = 1'b1; evt_pls = 2'b01;
        @(negedge clk); wr_en = 1'b0; wdata = '0; evt_pls = 2'b00;
        rdchk("R4 event wins", 3'd0, 8'h40);
        wr(3'd0, 8'h40);
        rdchk("R2 empd cleared", 3'd0, 8'h00);
        // R7 vendor gating
        @(negedge clk); vnd_pls = 8'h81;
        @(negedge clk); vnd_pls = 8'h00;
        rdchk("R7 disabled", 3'd2, 8'h00);
        rdchk("R6 no summary", 3'd1, 8'h00);
        wr(3'd3, 8'h01);
        rdchk("R7 enable rw", 3'd3, 8'h01);
        @(negedge clk); vnd_pls = 8'h81;
        @(negedge clk); vnd_pls = 8'h00;
        rdchk("R7 captured", 3'd2, 8'h01);
        rdchk("R6 summary", 3'd1, 8'h80);
        rdchk("R5 two level", 3'd0, 8'h80);
        wr(3'd1, 8'h80);
        rdchk("R6 write ignored", 3'd1, 8'h80);
        wr(3'd2, 8'h01);
        rdchk("R7 cleared", 3'd2, 8'h00);
        rdchk("R6 summary gone", 3'd1, 8'h00);
        // R9 force and R10 status
        wr(3'd4, 8'h01);
        rdchk("R9 ctl rw", 3'd4, 8'h01);
        chk("R9 irq forced", {7'd0, irq_n}, 8'h00);
        rdchk("R10 stat low", 3'd5, 8'h00);
        wr(3'd5, 8'hFF);
        rdchk("R10 write ignored", 3'd5, 8'h00);
        wr(3'd4, 8'h00);
        idle(1);
        rdchk("R10 stat high", 3'd5, 8'h20);
        chk("R9 released", {7'd0, irq_n}, 8'h01);
        rdchk("R11 unused 7", 3'd7, 8'h00);
        idle(2);
      end
      begin
        repeat (5000) @(negedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule